// File: doc/BRIEF.md
# Two-Level Cascaded Interrupt Controller

The controller gathers three banks of level-sensitive interrupt sources: two local banks of eight bits each and one shared bank of eight remappable bits. Each local bank has a mask. The remappable bank is read through one status view and has two separate masks. Each of those masks forms a cascade path that feeds one designated bit of one local bank. Software reaches the masks and the status views through a small byte-addressed register port. Writes to a mask land on the next clock. Software acknowledges a source by clearing its mask bit.

Every local bank yields a pending flag. The flag is registered once and is then driven on a CPU request line, next to four request lines that come from outside: a CPU timer, a bus error and two interval timers. A fixed-order arbiter picks the single most urgent line. When the winner is a local bank, the block also gives an 8-bit vector. The vector is the bank's base plus the index of its highest enabled bit. When that bank's cascade bit is the active one, the vector comes from the remappable path instead. A vector of zero means nothing is left to service.

The vector and its valid flag are a level output. There is no ready input and no back-pressure: the pair keeps showing the current winner until the sources or the masks change.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset all four mask registers read zero (offsets 1, 3, 5, 6), and CPU lines 2 and 3 are low.
- R2: Status reads are live views of the source inputs: offset 0 is local bank 0, offset 2 is local bank 1, offset 4 is the remappable bank. A write to any of these offsets changes nothing, and offset 7 reads zero.
- R3: A write to a mask offset is visible in the readback and in the request logic from the clock edge that samples the write.
- R4: Within an enabled bank, the highest set bit wins (bit 7 highest). The vector is the bank's base plus that bit index: local 0 base 16, local 1 base 24, remappable path 0 base 32, remappable path 1 base 40.
- R5: vec_valid is high only when vec is nonzero. An enabled bank whose masked value is zero gives vec 0.
- R6: Status bit 2 of local bank 0 reads as the OR of (remappable sources AND remappable mask 0). Status bit 3 of local bank 1 reads as the OR of (remappable sources AND remappable mask 1). The raw local inputs at those two bits are ignored.
- R7: The cascade bit of each local mask (bit 2 of mask 0, bit 3 of mask 1) reads 1 exactly when its remappable mask is nonzero. Direct writes to that bit are ignored.
- R8: When a local bank's cascade bit is set in its masked status, the vector comes from the remappable sources ANDed with that path's mask, using the path base.
- R9: cpu_lines bit 7 is cpu_timer, bit 6 is bus_err, bit 5 is tmr1, bit 4 is tmr0, and bits 1 and 0 are zero. Bit 2 (bit 3) is the OR of local bank 0's (bank 1's) masked status, delayed by one clock.
- R10: Line priority from highest to lowest is 7, 2, 3, 6, 4, 5. line_id names the highest active line, and line_valid is high when any of lines 2 to 7 is high.
- R11: When line_id is not 2 or 3, or when line_valid is low, vec reads 0 and vec_valid is low. When line_id is 2 or 3, vec is the vector of local bank 0 or 1 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| src_lcl0 | input | 8 | Local bank 0 source levels |
| src_lcl1 | input | 8 | Local bank 1 source levels |
| src_map | input | 8 | Remappable bank source levels |
| cpu_timer | input | 1 | CPU timer request (line 7) |
| bus_err | input | 1 | Bus error request (line 6) |
| tmr0 | input | 1 | Interval timer 0 request (line 4) |
| tmr1 | input | 1 | Interval timer 1 request (line 5) |
| cpu_lines | output | 8 | CPU request lines |
| line_valid | output | 1 | Some CPU line is pending |
| line_id | output | 3 | Highest-priority pending line |
| vec_valid | output | 1 | vec holds a nonzero vector |
| vec | output | 8 | Vector of the winning local bank |

## Verification
The bench builds the block with its default parameters. These are 8-bit banks, cascade bits 2 and 3, and bases 16, 24, 32 and 40, so every vector value the bench expects is a small, distinct number. With these values a vector that comes out of the wrong path or has the wrong base shows up as a wrong number. Random source and mask patterns combine with the six request lines so that every arbitration winner occurs. The directed cases cover the cascade bits: writes that try to set them, an enabled remappable source, and the clearing of the last remappable enable.

// File: rtl/irq_casc_pkg.sv
package irq_casc_pkg;

  typedef enum logic [2:0] {
    OFS_STAT0  = 3'd0,
    OFS_MASK0  = 3'd1,
    OFS_STAT1  = 3'd2,
    OFS_MASK1  = 3'd3,
    OFS_MSTAT  = 3'd4,
    OFS_MMASK0 = 3'd5,
    OFS_MMASK1 = 3'd6,
    OFS_NONE   = 3'd7
  } reg_ofs_e;

  localparam int unsigned NUM_LINES = 8;
  localparam int unsigned NUM_PRIO  = 6;
  // Index 0 is the most urgent line.
  localparam int unsigned LINE_ORDER [NUM_PRIO] = '{7, 2, 3, 6, 4, 5};

  localparam int unsigned LINE_LCL0 = 2;
  localparam int unsigned LINE_LCL1 = 3;

endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned W  = 8,
  parameter int unsigned VW = 8
) (
  input  logic [W-1:0]  req,
  input  logic [VW-1:0] base,
  output logic [VW-1:0] vec
);
  always_comb begin
    vec = '0;
    for (int i = 0; i < W; i++) begin
      if (req[i]) vec = base + VW'(i);
    end
  end
endmodule

// File: rtl/irq_group_path.sv
module irq_group_path #(
  parameter int unsigned W     = 8,
  parameter int unsigned VW    = 8,
  parameter int unsigned CASC  = 2,
  parameter int unsigned LBASE = 16,
  parameter int unsigned MBASE = 32
) (
  input  logic [W-1:0]  src,
  input  logic [W-1:0]  map_src,
  input  logic [W-1:0]  mask,
  input  logic [W-1:0]  map_mask,
  output logic [W-1:0]  status,
  output logic          pend,
  output logic [VW-1:0] vec
);
  localparam logic [VW-1:0] LB = VW'(LBASE);
  localparam logic [VW-1:0] MB = VW'(MBASE);

  logic [W-1:0]  map_masked;
  logic [W-1:0]  masked;
  logic [VW-1:0] lcl_vec;
  logic [VW-1:0] map_vec;

  assign map_masked = map_src & map_mask;

  always_comb begin
    status       = src;
    status[CASC] = |map_masked;
  end

  assign masked = status & mask;
  assign pend   = |masked;

  irq_prio_enc #(.W(W), .VW(VW)) u_lcl_enc (.req(masked),     .base(LB), .vec(lcl_vec));
  irq_prio_enc #(.W(W), .VW(VW)) u_map_enc (.req(map_masked), .base(MB), .vec(map_vec));

  assign vec = masked[CASC] ? map_vec : lcl_vec;
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_casc_pkg::*;
#(
  parameter int unsigned W     = 8,
  parameter int unsigned CASC0 = 2,
  parameter int unsigned CASC1 = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [2:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask0,
  output logic [W-1:0] mask1,
  output logic [W-1:0] mmask0,
  output logic [W-1:0] mmask1
);
  localparam logic [W-1:0] KEEP0 = ~(W'(1) << CASC0);
  localparam logic [W-1:0] KEEP1 = ~(W'(1) << CASC1);

  logic [W-1:0] mk0_q, mk1_q, mm0_q, mm1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mk0_q <= '0;
      mk1_q <= '0;
      mm0_q <= '0;
      mm1_q <= '0;
    end else if (wr) begin
      case (reg_ofs_e'(addr))
        OFS_MASK0:  mk0_q <= wdata & KEEP0;
        OFS_MASK1:  mk1_q <= wdata & KEEP1;
        OFS_MMASK0: mm0_q <= wdata;
        OFS_MMASK1: mm1_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    mask0        = mk0_q;
    mask0[CASC0] = |mm0_q;
    mask1        = mk1_q;
    mask1[CASC1] = |mm1_q;
  end

  assign mmask0 = mm0_q;
  assign mmask1 = mm1_q;
endmodule

// File: rtl/irq_line_arb.sv
module irq_line_arb
  import irq_casc_pkg::*;
(
  input  logic [NUM_LINES-1:0] lines,
  output logic                 valid,
  output logic [2:0]           id
);
  always_comb begin
    valid = 1'b0;
    id    = '0;
    for (int k = NUM_PRIO - 1; k >= 0; k--) begin
      if (lines[LINE_ORDER[k]]) begin
        valid = 1'b1;
        id    = 3'(LINE_ORDER[k]);
      end
    end
  end
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irq_casc_pkg::*;
#(
  parameter int unsigned W      = 8,
  parameter int unsigned VW     = 8,
  parameter int unsigned CASC0  = 2,
  parameter int unsigned CASC1  = 3,
  parameter int unsigned LBASE0 = 16,
  parameter int unsigned LBASE1 = 24,
  parameter int unsigned MBASE0 = 32,
  parameter int unsigned MBASE1 = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  input  logic [W-1:0]  src_lcl0,
  input  logic [W-1:0]  src_lcl1,
  input  logic [W-1:0]  src_map,
  input  logic          cpu_timer,
  input  logic          bus_err,
  input  logic          tmr0,
  input  logic          tmr1,
  output logic [7:0]    cpu_lines,
  output logic          line_valid,
  output logic [2:0]    line_id,
  output logic          vec_valid,
  output logic [VW-1:0] vec
);
  localparam int unsigned NGRP = 2;
  localparam int unsigned CASC_OF  [NGRP] = '{CASC0, CASC1};
  localparam int unsigned LBASE_OF [NGRP] = '{LBASE0, LBASE1};
  localparam int unsigned MBASE_OF [NGRP] = '{MBASE0, MBASE1};

  logic [W-1:0] eff_mask0, eff_mask1, mmask0, mmask1;

  logic [NGRP-1:0][W-1:0]  grp_src, grp_mask, grp_mmask, grp_stat;
  logic [NGRP-1:0][VW-1:0] grp_vec;
  logic [NGRP-1:0]         grp_pend;
  logic [NGRP-1:0]         req_q;

  irq_mask_regs #(.W(W), .CASC0(CASC0), .CASC1(CASC1)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .mask0(eff_mask0), .mask1(eff_mask1), .mmask0(mmask0), .mmask1(mmask1)
  );

  assign grp_src   = {src_lcl1, src_lcl0};
  assign grp_mask  = {eff_mask1, eff_mask0};
  assign grp_mmask = {mmask1, mmask0};

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    irq_group_path #(
      .W(W), .VW(VW), .CASC(CASC_OF[g]), .LBASE(LBASE_OF[g]), .MBASE(MBASE_OF[g])
    ) u_path (
      .src(grp_src[g]), .map_src(src_map), .mask(grp_mask[g]), .map_mask(grp_mmask[g]),
      .status(grp_stat[g]), .pend(grp_pend[g]), .vec(grp_vec[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= grp_pend;
  end

  assign cpu_lines = {cpu_timer, bus_err, tmr1, tmr0, req_q[1], req_q[0], 2'b00};

  irq_line_arb u_arb (.lines(cpu_lines), .valid(line_valid), .id(line_id));

  always_comb begin
    vec = '0;
    if (line_valid && line_id == 3'(LINE_LCL0)) vec = grp_vec[0];
    if (line_valid && line_id == 3'(LINE_LCL1)) vec = grp_vec[1];
  end
  assign vec_valid = |vec;

  always_comb begin
    case (reg_ofs_e'(reg_addr))
      OFS_STAT0:  reg_rdata = grp_stat[0];
      OFS_MASK0:  reg_rdata = eff_mask0;
      OFS_STAT1:  reg_rdata = grp_stat[1];
      OFS_MASK1:  reg_rdata = eff_mask1;
      OFS_MSTAT:  reg_rdata = src_map;
      OFS_MMASK0: reg_rdata = mmask0;
      OFS_MMASK1: reg_rdata = mmask1;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_cascade_ctrl_chk.sv
module irq_cascade_ctrl_chk #(
  parameter int unsigned W     = 8,
  parameter int unsigned VW    = 8,
  parameter int unsigned CASC0 = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [2:0]    reg_addr,
  input logic [W-1:0]  reg_wdata,
  input logic [W-1:0]  mask0,
  input logic [W-1:0]  stat0,
  input logic [7:0]    cpu_lines,
  input logic          line_valid,
  input logic [2:0]    line_id,
  input logic          vec_valid,
  input logic [VW-1:0] vec
);
  localparam logic [W-1:0] KEEP0 = ~(W'(1) << CASC0);

  assert_mask_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 3'd1 |=> (mask0 & KEEP0) == ($past(reg_wdata) & KEEP0));

  assert_casc_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 3'd5 |=> mask0[CASC0] == (|$past(reg_wdata)));

  assert_req_lag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> cpu_lines[2] == $past(|(stat0 & mask0)));

  assert_timer_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_lines[7] |-> line_valid && line_id == 3'd7);

  assert_lcl0_second_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_lines[2] && !cpu_lines[7] |-> line_id == 3'd2);

  assert_vec_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_valid && (line_id == 3'd2 || line_id == 3'd3)) |-> vec == '0 && !vec_valid);

  assert_vec_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> vec != '0);
endmodule

bind irq_cascade_ctrl irq_cascade_ctrl_chk #(.W(W), .VW(VW), .CASC0(CASC0)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .mask0(eff_mask0), .stat0(grp_stat[0]), .cpu_lines(cpu_lines),
  .line_valid(line_valid), .line_id(line_id), .vec_valid(vec_valid), .vec(vec)
);

// File: tb/test_irq_cascade_ctrl.sv
module test_irq_cascade_ctrl;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0, rst_n = 0;
  logic       reg_wr = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [7:0] src_lcl0 = 0, src_lcl1 = 0, src_map = 0;
  logic       cpu_timer = 0, bus_err = 0, tmr0 = 0, tmr1 = 0;
  logic [7:0] cpu_lines, vec;
  logic       line_valid, vec_valid;
  logic [2:0] line_id;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  // bench model of the mask registers
  logic [7:0] m_mk0 = 0, m_mk1 = 0, m_mm0 = 0, m_mm1 = 0;

  irq_cascade_ctrl i_irq_cascade_ctrl (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] penc(logic [7:0] v, logic [7:0] base);
    for (int i = 7; i >= 0; i--) if (v[i]) return base + 8'(i);
    return 8'd0;
  endfunction

  function automatic logic [7:0] e_mask(int g);
    logic [7:0] m;
    if (g == 0) begin m = m_mk0 & 8'hFB; m[2] = |m_mm0; end
    else        begin m = m_mk1 & 8'hF7; m[3] = |m_mm1; end
    return m;
  endfunction

  function automatic logic [7:0] e_stat(int g);
    logic [7:0] s;
    if (g == 0) begin s = src_lcl0; s[2] = |(src_map & m_mm0); end
    else        begin s = src_lcl1; s[3] = |(src_map & m_mm1); end
    return s;
  endfunction

  function automatic logic [7:0] e_gvec(int g);
    logic [7:0] m;
    m = e_stat(g) & e_mask(g);
    if (g == 0) return m[2] ? penc(src_map & m_mm0, 8'd32) : penc(m, 8'd16);
    return m[3] ? penc(src_map & m_mm1, 8'd40) : penc(m, 8'd24);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    case (a)
      3'd1: m_mk0 = d;
      3'd3: m_mk1 = d;
      3'd5: m_mm0 = d;
      3'd6: m_mm1 = d;
      default: ;
    endcase
  endtask

  task automatic settle();
    @(negedge clk); @(negedge clk);
  endtask

  task automatic rd_chk(string req, logic [2:0] a, logic [7:0] exp);
    reg_addr = a; #1;
    chk(req, reg_rdata, exp);
  endtask

  // Full port check against the bench model (R9, R10, R11, R4, R8, R5).
  task automatic check_outputs();
    logic [7:0] el, ev;
    logic [2:0] eid;
    logic       evld;
    el = {cpu_timer, bus_err, tmr1, tmr0, |(e_stat(1) & e_mask(1)), |(e_stat(0) & e_mask(0)), 2'b00};
    chk("R9 cpu_lines", cpu_lines, el);
    evld = 1; eid = 0;
    if (el[7]) eid = 7; else if (el[2]) eid = 2; else if (el[3]) eid = 3;
    else if (el[6]) eid = 6; else if (el[4]) eid = 4; else if (el[5]) eid = 5;
    else evld = 0;
    chk("R10 line_valid", line_valid, evld);
    chk("R10 line_id", line_id, eid);
    ev = 0;
    if (evld && eid == 2) ev = e_gvec(0);
    if (evld && eid == 3) ev = e_gvec(1);
    chk("R4 R8 R11 vec", vec, ev);
    chk("R5 vec_valid", vec_valid, ev != 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd_chk("R1 mask0", 3'd1, 8'h00);
    rd_chk("R1 mask1", 3'd3, 8'h00);
    rd_chk("R1 mmask0", 3'd5, 8'h00);
    rd_chk("R1 mmask1", 3'd6, 8'h00);
    chk("R1 lines", cpu_lines[3:2], 2'b00);

    // R2 status views and ignored writes
    src_lcl0 = 8'hA1; src_lcl1 = 8'h52; src_map = 8'h3C;
    wr(3'd0, 8'h00); wr(3'd2, 8'hFF); wr(3'd4, 8'h00);
    settle();
    rd_chk("R2 stat0", 3'd0, 8'hA1);
    rd_chk("R2 stat1", 3'd2, 8'h52);
    rd_chk("R2 mstat", 3'd4, 8'h3C);
    rd_chk("R2 ofs7", 3'd7, 8'h00);
    rd_chk("R2 mask0 unchanged", 3'd1, 8'h00);

    // R7 direct cascade-bit writes ignored
    wr(3'd1, 8'hFF); wr(3'd3, 8'hFF);
    rd_chk("R7 mask0 casc", 3'd1, 8'hFB);
    rd_chk("R7 mask1 casc", 3'd3, 8'hF7);

    // R3 R4 local vector: bank0 0xA1 -> bit7 -> 23
    wr(3'd3, 8'h00);
    settle();
    check_outputs();
    chk("R4 vec 23", vec, 8'd23);

    // R6 R8 cascade path 0: map 0x3C & 0x0C -> bit3 -> 35; stat0 bit2 set
    src_lcl0 = 8'h00;
    wr(3'd5, 8'h0C);
    settle();
    rd_chk("R6 stat0 casc", 3'd0, 8'h04);
    rd_chk("R7 mask0 auto", 3'd1, 8'hFF);
    check_outputs();
    chk("R8 vec 35", vec, 8'd35);

    // R7 clearing remappable mask clears cascade bit
    wr(3'd5, 8'h00);
    settle();
    rd_chk("R7 mask0 cleared", 3'd1, 8'hFB);
    chk("R5 nothing pending", {vec_valid, vec}, 9'd0);

    // R10 timer beats local
    src_lcl0 = 8'h01; cpu_timer = 1;
    settle();
    check_outputs();
    chk("R11 timer wins vec", vec, 8'd0);
    cpu_timer = 0;
    settle();
    chk("R4 vec 16", vec, 8'd16);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int unsigned r = $urandom % 4;
      if (r == 0) wr(3'($urandom % 8), 8'($urandom));
      else begin
        @(negedge clk);
        src_lcl0 = 8'($urandom); src_lcl1 = 8'($urandom); src_map = 8'($urandom);
        cpu_timer = ($urandom % 8) == 0; bus_err = ($urandom % 3) == 0;
        tmr0 = ($urandom % 2) == 0; tmr1 = ($urandom % 2) == 0;
        if (($urandom % 3) == 0) src_lcl0 = 8'h00;
      end
      settle();
      check_outputs();
      rd_chk("R3 R7 mask0 rb", 3'd1, e_mask(0));
      rd_chk("R6 stat1 rb", 3'd2, e_stat(1));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule